// File: doc/BRIEF.md
# Predicated Vector Float/Fixed Converter

This block converts every lane of a 128-bit vector between IEEE binary floating point and a fixed-point integer that carries a chosen number of fraction bits. The element size is 16 bits (half precision against 16-bit integers, eight lanes) or 32 bits (single precision against 32-bit integers, four lanes). Decoded control inputs select the integer's signedness and the direction. A start strobe launches one operation. One clock edge later the merged destination vector is registered and a one-cycle done pulse marks it.

A predicate of one bit per byte decides which destination bytes take the new result. All other bytes keep the old destination value, which the caller supplies on `dst_in`. A lane is computed when any of its bytes is enabled. It may raise exception flags only when the predicate bit of its lowest byte is set. The flags of all eligible lanes collect into a sticky two-bit output, which only reset clears.

Top module: `vcvt_fixfloat`

## Requirements
- R1: While `rst` is high at a clock edge, `dst` becomes zero, `done` becomes 0 and `flags` becomes 0.
- R2: A `start` sampled high at an edge gives `done`=1 for exactly the following cycle, with the new `dst` and `flags`. Without `start`, `dst` and `flags` hold and `done` stays 0.
- R3: The fraction-bit count is 32 minus `frac_imm[4:0]` for 32-bit lanes, so 0 selects 32. For 16-bit lanes it is 16 minus `frac_imm[3:0]`, so 0 selects 16, and `frac_imm[4]` is ignored.
- R4: Fixed to float (`op_to_fixed`=0) yields the integer times 2^-fbits, rounded to nearest with ties to even. It sets the inexact flag when rounding discards a nonzero remainder.
- R5: In half precision, fixed-to-float results below 2^-14 are encoded as subnormals and are not flushed.
- R6: Float to fixed (`op_to_fixed`=1) multiplies by 2^fbits and truncates toward zero. It sets inexact when nonzero bits are dropped, including a negative value that truncates to 0 in an unsigned conversion.
- R7: Float to fixed saturates out-of-range values to the target's maximum, or to its minimum (0 for unsigned), and sets invalid and not inexact. For a signed target, exactly -2^(W-1) converts without a flag.
- R8: Float to fixed turns any NaN into 0 with invalid, and turns an infinity into the saturated limit of its sign with invalid.
- R9: `dst` byte j takes the result when `pred[j]` is 1 and `dst_in` byte j otherwise, so a lane with no enabled byte is left unchanged.
- R10: A lane contributes flags only when the predicate bit of its lowest byte (`pred[2i]` for 16-bit lanes, `pred[4i]` for 32-bit lanes) is 1.
- R11: `flags[1]` is invalid and `flags[0]` is inexact. On each operation they are ORed with the eligible lanes' flags, and they stay set until reset.
- R12: Lane i occupies bits [W*i +: W] of `src`, `dst_in` and `dst`, with W = 16 when `op_single`=0 and W = 32 when it is 1. Signed integers are two's complement, and `op_signed`=1 selects signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one conversion using the inputs sampled at this edge |
| op_single | input | 1 | 1: four 32-bit lanes, 0: eight 16-bit lanes |
| op_to_fixed | input | 1 | 1: float to fixed, 0: fixed to float |
| op_signed | input | 1 | Integer side is signed two's complement |
| frac_imm | input | 5 | Encoded fraction-bit count |
| src | input | 128 | Source vector |
| dst_in | input | 128 | Previous destination contents, kept in disabled bytes |
| pred | input | 16 | Per-byte write enable and flag gate |
| dst | output | 128 | Registered destination vector |
| done | output | 1 | One-cycle pulse with a new result |
| flags | output | 2 | Sticky {invalid, inexact} |

## Verification
A wrong rounding or scaling decision inside a lane appears on `dst` in the cycle right after the strobe, together with `done`. The hand-chosen operands sit on ties, saturation edges and subnormal boundaries, so an off-by-one exponent or a missing carry changes a visible bit. A flag raised by a lane that should be gated stays on the sticky output and shows up at the next comparison. Every test group therefore starts from reset, so a stray flag cannot be masked by an earlier legitimate one. A bad byte merge shows as `dst_in` bytes in the wrong place within one operation.

// File: rtl/vcvt_pkg.sv
package vcvt_pkg;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } vcvt_flags_t;

    typedef struct packed {
        logic       single;
        logic       to_fixed;
        logic       sgn;
        logic [4:0] imm;
    } vcvt_ctrl_t;

    // Decoded fraction-bit count (shift-right immediate style encoding).
    function automatic int frac_bits(input logic single, input logic [4:0] imm);
        if (single) return 32 - int'({27'd0, imm});
        return 16 - int'({28'd0, imm[3:0]});
    endfunction

    // Integer of width w scaled by 2^-f to binary float, round to nearest even.
    function automatic logic [31:0] fix_to_float(
        input logic [31:0] x, input logic sgn, input int w, input int m,
        input int bias, input int f, output logic inx);
        logic [63:0] wmask, mag, q, rem, half, bits, base_v;
        logic        neg, up;
        logic [31:0] r;
        int          p, s, emin, base;
        inx   = 1'b0;
        wmask = (64'd1 << w) - 64'd1;
        neg   = sgn && x[w-1];
        mag   = {32'd0, x} & wmask;
        if (neg) mag = (~mag + 64'd1) & wmask;
        p = -1;
        for (int i = 0; i < 32; i++) if (mag[i]) p = i;
        if (p < 0) return 32'd0;
        emin = 1 - bias;
        s    = p - m;
        if (emin - m + f > s) s = emin - m + f;
        base = (s == p - m) ? (p - f + bias - 1) : 0;
        if (s <= 0) begin
            q = mag << (-s);
        end else begin
            q    = mag >> s;
            rem  = mag & ((64'd1 << s) - 64'd1);
            half = 64'd1 << (s - 1);
            inx  = (rem != 64'd0);
            up   = (rem > half) || ((rem == half) && q[0]);
            q    = q + {63'd0, up};
        end
        base_v = 64'(base);
        bits   = (base_v << m) + q;
        r      = bits[31:0];
        if (neg) r[w-1] = 1'b1;
        return r;
    endfunction

    // Binary float to integer of width w scaled by 2^f, truncating toward zero.
    function automatic logic [31:0] float_to_fix(
        input logic [31:0] a, input logic sgn, input int w, input int m,
        input int ew, input int bias, input int f,
        output logic inv, output logic inx);
        logic [63:0] wmask, maxv, negl, lim, sig, mag, res;
        logic        neg, over;
        int          ex, emax, eu, sh;
        inv   = 1'b0;
        inx   = 1'b0;
        over  = 1'b0;
        mag   = 64'd0;
        wmask = (64'd1 << w) - 64'd1;
        ex    = int'((a >> m) & ((32'd1 << ew) - 32'd1));
        emax  = (1 << ew) - 1;
        neg   = a[w-1];
        sig   = {32'd0, a & ((32'd1 << m) - 32'd1)};
        maxv  = sgn ? (64'd1 << (w - 1)) - 64'd1 : wmask;
        negl  = sgn ? (64'd1 << (w - 1)) : 64'd0;
        lim   = neg ? negl : maxv;
        if (ex == emax) begin
            inv = 1'b1;
            res = (sig != 64'd0) ? 64'd0 : (neg ? negl : maxv);
        end else begin
            if (ex != 0) sig = sig | (64'd1 << m);
            eu = ((ex == 0) ? 1 : ex) - bias;
            sh = eu - m + f;
            if (sig == 64'd0)  mag = 64'd0;
            else if (sh > 32)  over = 1'b1;
            else if (sh >= 0)  mag = sig << sh;
            else if (sh <= -40) begin
                mag = 64'd0;
                inx = 1'b1;
            end else begin
                mag = sig >> (-sh);
                inx = ((sig & ((64'd1 << (-sh)) - 64'd1)) != 64'd0);
            end
            if (over || (mag > lim)) begin
                inv = 1'b1;
                inx = 1'b0;
                res = neg ? negl : maxv;
            end else begin
                res = neg ? (~mag + 64'd1) : mag;
            end
        end
        res = res & wmask;
        return res[31:0];
    endfunction

endpackage

// File: rtl/vcvt_lane.sv
module vcvt_lane
    import vcvt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  vcvt_ctrl_t   ctrl,
    output logic [W-1:0] r,
    output vcvt_flags_t  fl
);
    localparam int MANT = (W == 16) ? 10 : 23;
    localparam int EXPW = (W == 16) ? 5 : 8;
    localparam int BIAS = (1 << (EXPW - 1)) - 1;

    logic [31:0] a_ext, res;
    logic        f_inv, f_inx, i_inx;
    int          fb;

    always_comb begin
        a_ext = 32'd0;
        a_ext[W-1:0] = a;
        fb = frac_bits(ctrl.single, ctrl.imm);
        f_inv = 1'b0;
        f_inx = 1'b0;
        i_inx = 1'b0;
        if (ctrl.to_fixed) begin
            res = float_to_fix(a_ext, ctrl.sgn, W, MANT, EXPW, BIAS, fb, f_inv, f_inx);
            fl.invalid = f_inv;
            fl.inexact = f_inx;
        end else begin
            res = fix_to_float(a_ext, ctrl.sgn, W, MANT, BIAS, fb, i_inx);
            fl.invalid = 1'b0;
            fl.inexact = i_inx;
        end
        r = res[W-1:0];
    end
endmodule

// File: rtl/vcvt_merge.sv
module vcvt_merge
    import vcvt_pkg::*;
#(
    parameter int VEC_BITS = 128
) (
    input  logic                         single,
    input  logic [VEC_BITS/8-1:0]        pred,
    input  logic [VEC_BITS-1:0]          res16,
    input  logic [VEC_BITS-1:0]          res32,
    input  logic [VEC_BITS-1:0]          old,
    input  vcvt_flags_t [VEC_BITS/16-1:0] fl16,
    input  vcvt_flags_t [VEC_BITS/32-1:0] fl32,
    output logic [VEC_BITS-1:0]          merged,
    output vcvt_flags_t                  fl_or
);
    localparam int NB  = VEC_BITS / 8;
    localparam int N16 = VEC_BITS / 16;
    localparam int N32 = VEC_BITS / 32;

    logic [VEC_BITS-1:0] res;
    assign res = single ? res32 : res16;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged[8*b +: 8] = pred[b] ? res[8*b +: 8] : old[8*b +: 8];
    end

    vcvt_flags_t [N16-1:0] gate16;
    vcvt_flags_t [N32-1:0] gate32;
    for (genvar i = 0; i < N16; i++) begin : g_gate16
        assign gate16[i] = pred[2*i] ? fl16[i] : '0;
    end
    for (genvar i = 0; i < N32; i++) begin : g_gate32
        assign gate32[i] = pred[4*i] ? fl32[i] : '0;
    end

    always_comb begin
        fl_or = '0;
        if (single) begin
            for (int i = 0; i < N32; i++) fl_or = fl_or | gate32[i];
        end else begin
            for (int i = 0; i < N16; i++) fl_or = fl_or | gate16[i];
        end
    end
endmodule

// File: rtl/vcvt_fixfloat.sv
module vcvt_fixfloat
    import vcvt_pkg::*;
#(
    parameter int VEC_BITS = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  op_single,
    input  logic                  op_to_fixed,
    input  logic                  op_signed,
    input  logic [4:0]            frac_imm,
    input  logic [VEC_BITS-1:0]   src,
    input  logic [VEC_BITS-1:0]   dst_in,
    input  logic [VEC_BITS/8-1:0] pred,
    output logic [VEC_BITS-1:0]   dst,
    output logic                  done,
    output logic [1:0]            flags
);
    localparam int NB  = VEC_BITS / 8;
    localparam int N16 = VEC_BITS / 16;
    localparam int N32 = VEC_BITS / 32;

    vcvt_ctrl_t ctrl;
    assign ctrl = '{single: op_single, to_fixed: op_to_fixed, sgn: op_signed, imm: frac_imm};

    logic [VEC_BITS-1:0]  res16, res32, merged;
    vcvt_flags_t [N16-1:0] fl16;
    vcvt_flags_t [N32-1:0] fl32;
    vcvt_flags_t           fl_or, flags_q;

    for (genvar i = 0; i < N16; i++) begin : g_h
        vcvt_lane #(.W(16)) u_lane (
            .a(src[16*i +: 16]), .ctrl(ctrl), .r(res16[16*i +: 16]), .fl(fl16[i]));
    end
    for (genvar i = 0; i < N32; i++) begin : g_s
        vcvt_lane #(.W(32)) u_lane (
            .a(src[32*i +: 32]), .ctrl(ctrl), .r(res32[32*i +: 32]), .fl(fl32[i]));
    end

    vcvt_merge #(.VEC_BITS(VEC_BITS)) u_merge (
        .single(op_single), .pred(pred), .res16(res16), .res32(res32),
        .old(dst_in), .fl16(fl16), .fl32(fl32), .merged(merged), .fl_or(fl_or));

    always_ff @(posedge clk) begin
        if (rst) begin
            dst     <= '0;
            done    <= 1'b0;
            flags_q <= '0;
        end else begin
            done <= start;
            if (start) begin
                dst     <= merged;
                flags_q <= flags_q | fl_or;
            end
        end
    end
    assign flags = flags_q;

    // Lanes whose lowest predicate bit is set, for the current element size.
    logic [NB-1:0] low_mask;
    always_comb begin
        low_mask = '0;
        for (int b = 0; b < NB; b++)
            low_mask[b] = op_single ? ((b % 4) == 0) : ((b % 2) == 0);
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    p_done_cause_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));
    p_hold_dst_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(dst) && $stable(flags)));
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags)) == $past(flags)));
    p_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        (start && pred == '0) |=> (dst == $past(dst_in)));
    p_flag_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (start && (pred & low_mask) == '0) |=> $stable(flags));
    for (genvar i = 0; i < N32; i++) begin : g_chk
        p_nan_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (start && op_single && op_to_fixed && src[32*i+23 +: 8] == 8'hFF &&
             src[32*i +: 23] != 23'd0 && pred[4*i +: 4] == 4'hF)
            |=> (dst[32*i +: 32] == 32'd0 && flags[1]));
    end
endmodule

// File: tb/tb_vcvt_fixfloat.sv
`timescale 1ns/1ps
module tb_vcvt_fixfloat;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op_single = 1'b0, op_to_fixed = 1'b0, op_signed = 1'b0;
    logic [4:0]   frac_imm = 5'd0;
    logic [127:0] src = '0, dst_in = '0;
    logic [15:0]  pred = '0;
    logic [127:0] dst;
    logic         done;
    logic [1:0]   flags;

    vcvt_fixfloat dut (
        .clk(clk), .rst(rst), .start(start), .op_single(op_single),
        .op_to_fixed(op_to_fixed), .op_signed(op_signed), .frac_imm(frac_imm),
        .src(src), .dst_in(dst_in), .pred(pred), .dst(dst), .done(done), .flags(flags));

    always #4 clk = ~clk;

    typedef struct {
        logic [127:0] d;
        logic [1:0]   f;
        string        req;
    } sb_t;
    sb_t sb_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] model_flags = 2'b00;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected results as done pulses appear.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected done", 128'(done), 128'd0);
            end else begin
                sb_t it;
                it = sb_q.pop_front();
                check(dst === it.d, it.req, dst, it.d);
                check(flags === it.f, {it.req, " R11 flags"}, 128'(flags), 128'(it.f));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dst === '0, "R1 dst", dst, '0);
        check(flags === 2'b00, "R1 flags", 128'(flags), 128'd0);
        check(done === 1'b0, "R1 done", 128'(done), 128'd0);
        model_flags = 2'b00;
        rst = 1'b0;
    endtask

    task automatic run_op(input logic sgl, input logic tofx, input logic sg,
                          input logic [4:0] imm, input logic [127:0] s,
                          input logic [127:0] old, input logic [15:0] pm,
                          input logic [127:0] exp_d, input logic [1:0] opf,
                          input string req);
        sb_t it;
        @(negedge clk);
        op_single = sgl; op_to_fixed = tofx; op_signed = sg; frac_imm = imm;
        src = s; dst_in = old; pred = pm; start = 1'b1;
        model_flags = model_flags | opf;
        it.d = exp_d; it.f = model_flags; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R2 done single pulse", 128'(done), 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        do_reset();
        // R4 R12: signed 32-bit, fbits=1 (imm 31), exact
        run_op(1, 0, 1, 5'd31, {32'h3, 32'h0, 32'hFFFFFFFE, 32'h2}, '0, 16'hFFFF,
               {32'h3FC00000, 32'h0, 32'hBF800000, 32'h3F800000}, 2'b00, "R4 R12 sfix32");
        // R3 R4: unsigned 32-bit, imm 0 -> 32 fraction bits, ties to even
        run_op(1, 0, 0, 5'd0, {32'h01000003, 32'h01000001, 32'hFFFFFFFF, 32'h80000000},
               '0, 16'hFFFF,
               {32'h3B800002, 32'h3B800000, 32'h3F800000, 32'h3F000000}, 2'b01, "R3 R4 ufix32");
        // R3 R5: signed 16-bit, imm 5'h10 -> imm[4] ignored, 16 fraction bits, subnormals
        run_op(0, 0, 1, 5'h10,
               {16'h0003, 16'h8000, 16'h0002, 16'h0000, 16'h7FFF, 16'h4000, 16'hFFFF, 16'h0001},
               '0, 16'hFFFF,
               {16'h0300, 16'hB800, 16'h0200, 16'h0000, 16'h3800, 16'h3400, 16'h8100, 16'h0100},
               2'b01, "R3 R5 sfix16");
        do_reset();
        // R9 R10: partial predicate, NaN lane lowest byte disabled -> no flag
        run_op(1, 1, 1, 5'd31, {32'h4F000000, 32'h7FC00000, 32'hBFA00000, 32'h3FC00000},
               {4{32'hAAAAAAAA}}, 16'h0E0F,
               {32'hAAAAAAAA, 32'h000000AA, 32'hAAAAAAAA, 32'h00000003}, 2'b00, "R9 R10 gated");
        // R10: only lowest byte of NaN lane enabled -> invalid raised
        run_op(1, 1, 1, 5'd31, {32'h4F000000, 32'h7FC00000, 32'hBFA00000, 32'h3FC00000},
               {4{32'hAAAAAAAA}}, 16'h0100,
               {32'hAAAAAAAA, 32'hAAAAAA00, 32'hAAAAAAAA, 32'hAAAAAAAA}, 2'b10, "R10 lowbyte");
        // R6 R7 R8: full predicate, truncation, NaN, saturation
        run_op(1, 1, 1, 5'd31, {32'h4F000000, 32'h7FC00000, 32'hBFA00000, 32'h3FC00000},
               {4{32'hAAAAAAAA}}, 16'hFFFF,
               {32'h7FFFFFFF, 32'h00000000, 32'hFFFFFFFE, 32'h00000003}, 2'b11, "R6 R7 R8 sflt32");
        do_reset();
        // R6 R9: unsigned 16-bit, fbits=1, lanes 0,1,6,7 enabled
        run_op(0, 1, 0, 5'd15,
               {16'h3C00, 16'h0001, 16'h0000, 16'h7C00, 16'h7BFF, 16'hBC00, 16'hB400, 16'h3E00},
               {8{16'h5555}}, 16'hF00F,
               {16'h0002, 16'h0000, 16'h5555, 16'h5555, 16'h5555, 16'h5555, 16'h0000, 16'h0003},
               2'b01, "R6 R9 uflt16 part");
        // R7 R8: same, all lanes
        run_op(0, 1, 0, 5'd15,
               {16'h3C00, 16'h0001, 16'h0000, 16'h7C00, 16'h7BFF, 16'hBC00, 16'hB400, 16'h3E00},
               {8{16'h5555}}, 16'hFFFF,
               {16'h0002, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0003},
               2'b11, "R7 R8 uflt16");
        do_reset();
        // R7: signed 16-bit limits, 16 fraction bits
        run_op(0, 1, 1, 5'd0,
               {16'h0, 16'h0, 16'h0, 16'h0, 16'h0000, 16'h3400, 16'hB800, 16'h3800},
               '0, 16'hFFFF,
               {16'h0, 16'h0, 16'h0, 16'h0, 16'h0000, 16'h4000, 16'h8000, 16'h7FFF},
               2'b10, "R7 sflt16 limits");
        // R6 R7: unsigned 32-bit, 32 fraction bits
        run_op(1, 1, 0, 5'd0, {32'h2B800000, 32'h3F800000, 32'h3F7FFFFF, 32'h3F000000},
               '0, 16'hFFFF,
               {32'h00000000, 32'hFFFFFFFF, 32'hFFFFFF00, 32'h80000000}, 2'b11, "R6 R7 uflt32");
        // R2: hold without start
        held = dst;
        src = '1; dst_in = '1; pred = 16'hFFFF;
        @(negedge clk);
        check(dst === held, "R2 hold dst", dst, held);
        check(done === 1'b0, "R2 idle done", 128'(done), 128'd0);
        check(flags === 2'b11, "R11 hold flags", 128'(flags), 128'd3);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2 missing done", 128'(sb_q.size()), 128'd0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule